// File: doc/BRIEF.md
# Slot Interrupt Merger

This unit gathers the interrupt request lines of four plug-in module slots (two lines per slot) and folds them into one host interrupt. Software configures each slot through an 8-bit control byte. The byte switches each request line on or off, chooses edge or level sensing for it, and holds four further mode bits that are stored and read back. A 16-bit pending word records which lines have raised a request and which slots have timed out. Software reads the pending word and clears it by writing ones to it.

Level-sensing lines drive a held host level. Edge-sensing lines give a single-clock host pulse. Writing a one to a line's pending bit does not clear that bit. It sends a one-clock acknowledge to the slot, and the slot is then expected to drop its request. The resulting change on the line clears the bit. All registers sit on a simple synchronous 16-bit register port with byte addresses.

Top module: `slot_irq_unit`

## Requirements
- R1: After reset, every control byte, the pending word, every acknowledge output and host_irq are 0.
- R2: Register word index is bus_addr[7:1]; bit 0 is ignored. Index 0 (revision) and index 5 (reset) read 0, and writes to them are ignored. Indices 1 to 4 hold the control bytes of slots 0 to 3: they read as {8'h00, byte} and are written from bus_wdata[7:0]. Index 6 reads the pending word. Every other index reads 0.
- R3: In a slot's control byte, bit 6+k switches line k on and bit 4+k makes line k edge sensing. While a line is switched off, changes on it leave the pending word and host_irq untouched.
- R4: For a switched-on line, pending bit 2n+k (slot n, line k) takes the new request level at the clock edge that follows a change on slot_req[2n+k]. A change that does not alter the bit is not an event.
- R5: When a level-sensing line's pending bit changes, the held host level is recomputed at that edge. It is 1 if any bit of the next pending word (including timeout bits) remains set after the bits of edge-sensing lines are removed, and 0 otherwise. It holds between such events.
- R6: A rising change on an edge-sensing line gives host_irq a pulse exactly one clock wide, but only if no host level is being held. A falling change on an edge-sensing line produces no host activity.
- R7: host_irq rises only at an edge where the pending word changes.
- R8: Writing index 6 with bit 2n+k set raises slot_ack[2n+k] for exactly the next clock. The write does not itself clear that pending bit.
- R9: A high slot_tmo[n] sets pending bit 12+n. Writing index 6 with bit 12+n set clears it, and a set in the same cycle takes precedence.
- R10: Pending bits 8 to 11 always read 0, and writing ones to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| slot_req | input | 8 | Request lines, bit 2n+k for slot n line k |
| slot_tmo | input | 4 | Timeout events, one per slot |
| slot_ack | output | 8 | One-clock acknowledge per request line |
| host_irq | output | 1 | Merged host interrupt |

## Verification
The assertions assume that slot_req, slot_tmo and the register port are synchronous to clk and stable around each rising edge, and that bus_addr is always a defined value. They also assume that acknowledges come only from register writes, so an acknowledge can be traced back one cycle to a write. The bench changes every input on the falling edge. It only ever drives defined values, and it lets its slot models lower a request after seeing the acknowledge. This keeps every stimulus inside those assumptions while the random mix still covers switched-off lines, mode changes made while requests are pending, and timeout sets that collide with clears.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  localparam int SLOTS   = 4;
  localparam int LINES   = 2;
  localparam int NREQ    = SLOTS * LINES;
  localparam int REG_W   = 16;
  localparam int CTRL_W  = 8;
  localparam int ERR_LO  = NREQ;
  localparam int ERR_N   = 4;
  localparam int TMO_LO  = ERR_LO + ERR_N;
  localparam int CB_EDGE = 4;
  localparam int CB_EN   = 6;
  localparam int W_REV   = 0;
  localparam int W_CTRL  = 1;
  localparam int W_RST   = 5;
  localparam int W_STAT  = 6;

  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [REG_W-1:0]  word_t;
endpackage

// File: rtl/slot_irq_regs.sv
module slot_irq_regs
  import slot_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  word_t                         bus_wdata,
  input  word_t                         st_q,
  output logic [SLOTS-1:0][CTRL_W-1:0]  ctrl_q,
  output logic                          wr_stat,
  output word_t                         bus_rdata
);
  localparam int WI_W = ADDR_W - 1;

  logic [WI_W-1:0]                widx;
  logic [SLOTS-1:0]               ctrl_we;
  logic [SLOTS-1:0][CTRL_W-1:0]   ctrl_d;
  logic                           unused_rg;

  assign widx      = bus_addr[ADDR_W-1:1];
  assign wr_stat   = bus_we && (widx == WI_W'(W_STAT));
  assign unused_rg = ^{bus_addr[0], bus_wdata};

  for (genvar n = 0; n < SLOTS; n++) begin : g_ctrl
    assign ctrl_we[n] = bus_we && (widx == WI_W'(W_CTRL + n));

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we[n] |=> ctrl_q[n] == $past(bus_wdata[CTRL_W-1:0]));
  end

  always_comb begin
    for (int n = 0; n < SLOTS; n++) begin
      ctrl_d[n] = ctrl_we[n] ? bus_wdata[CTRL_W-1:0] : ctrl_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (widx == WI_W'(W_STAT)) begin
      bus_rdata = st_q;
    end
    for (int n = 0; n < SLOTS; n++) begin
      if (widx == WI_W'(W_CTRL + n)) begin
        bus_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q[n]};
      end
    end
  end
endmodule

// File: rtl/slot_irq_status.sv
module slot_irq_status
  import slot_irq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREQ-1:0]               req_i,
  input  logic [SLOTS-1:0]              tmo_i,
  input  logic [SLOTS-1:0][CTRL_W-1:0]  ctrl_q,
  input  logic                          wr_stat,
  input  word_t                         wdata,
  output word_t                         st_q,
  output word_t                         st_d,
  output logic [NREQ-1:0]               edge_mask,
  output logic                          lvl_evt,
  output logic                          edge_rise,
  output logic [NREQ-1:0]               ack_o
);
  logic [NREQ-1:0] req_q;
  logic [NREQ-1:0] line_en;
  logic [NREQ-1:0] chg;
  logic [NREQ-1:0] lvl_hit;
  logic [NREQ-1:0] rise;
  logic [NREQ-1:0] ack_d;
  logic            unused_sts;

  assign unused_sts = ^{wdata, ctrl_q};

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      line_en[i]   = ctrl_q[i / LINES][CB_EN + (i % LINES)];
      edge_mask[i] = ctrl_q[i / LINES][CB_EDGE + (i % LINES)];
      chg[i]       = line_en[i] & (req_i[i] ^ req_q[i]) & (req_i[i] ^ st_q[i]);
      lvl_hit[i]   = chg[i] & ~edge_mask[i];
      rise[i]      = chg[i] & edge_mask[i] & req_i[i];
    end
  end

  always_comb begin
    st_d = '0;
    for (int i = 0; i < NREQ; i++) begin
      st_d[i] = chg[i] ? req_i[i] : st_q[i];
    end
    for (int n = 0; n < SLOTS; n++) begin
      st_d[TMO_LO + n] = tmo_i[n] |
                         (st_q[TMO_LO + n] & ~(wr_stat & wdata[TMO_LO + n]));
    end
  end

  assign ack_d     = wr_stat ? wdata[NREQ-1:0] : '0;
  assign lvl_evt   = |lvl_hit;
  assign edge_rise = |rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      st_q  <= '0;
      ack_o <= '0;
    end else begin
      req_q <= req_i;
      st_q  <= st_d;
      ack_o <= ack_d;
    end
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_line_chk
    localparam int S = i / LINES;
    localparam int L = i % LINES;
    // R3
    off_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[S][CB_EN + L] |=> st_q[i] == $past(st_q[i]));
    // R8
    ack_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o[i] |-> $past(wr_stat && wdata[i]));
  end

  for (genvar n = 0; n < SLOTS; n++) begin : g_tmo_chk
    // R9
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[TMO_LO + n] && !tmo_i[n]) |=> !st_q[TMO_LO + n]);
    // R9
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_i[n] |=> st_q[TMO_LO + n]);
  end
endmodule

// File: rtl/slot_irq_host.sv
module slot_irq_host
  import slot_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  word_t           st_d,
  input  logic [NREQ-1:0] edge_mask,
  input  logic            lvl_evt,
  input  logic            edge_rise,
  output logic            host_irq
);
  word_t lvl_src;
  logic  lvl_q;
  logic  lvl_d;
  logic  pulse_d;
  logic  host_d;

  assign lvl_src = st_d & ~{{(REG_W-NREQ){1'b0}}, edge_mask};
  assign lvl_d   = lvl_evt ? (|lvl_src) : lvl_q;
  assign pulse_d = edge_rise & ~lvl_q;
  assign host_d  = lvl_d | pulse_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      lvl_q    <= lvl_d;
      host_irq <= host_d;
    end
  end

  // R5
  lvl_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(lvl_evt));
  // R5
  lvl_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> $past(lvl_evt));
endmodule

// File: rtl/slot_irq_unit.sv
module slot_irq_unit
  import slot_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NREQ-1:0]   slot_req,
  input  logic [SLOTS-1:0]  slot_tmo,
  output logic [NREQ-1:0]   slot_ack,
  output logic              host_irq
);
  logic [SLOTS-1:0][CTRL_W-1:0] ctrl_q;
  logic                         wr_stat;
  word_t                        st_q;
  word_t                        st_d;
  logic [NREQ-1:0]              edge_mask;
  logic                         lvl_evt;
  logic                         edge_rise;

  slot_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .st_q      (st_q),
    .ctrl_q    (ctrl_q),
    .wr_stat   (wr_stat),
    .bus_rdata (bus_rdata)
  );

  slot_irq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (slot_req),
    .tmo_i     (slot_tmo),
    .ctrl_q    (ctrl_q),
    .wr_stat   (wr_stat),
    .wdata     (bus_wdata),
    .st_q      (st_q),
    .st_d      (st_d),
    .edge_mask (edge_mask),
    .lvl_evt   (lvl_evt),
    .edge_rise (edge_rise),
    .ack_o     (slot_ack)
  );

  slot_irq_host u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_d      (st_d),
    .edge_mask (edge_mask),
    .lvl_evt   (lvl_evt),
    .edge_rise (edge_rise),
    .host_irq  (host_irq)
  );

  // R7
  host_rise_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> !$stable(st_q));
  // R10
  err_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[TMO_LO-1:ERR_LO] == '0);
endmodule

// File: tb/sim_slot_irq_unit.sv
module sim_slot_irq_unit;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  slot_req;
  logic [3:0]  slot_tmo;
  logic [7:0]  slot_ack;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;
  bit done   = 0;

  slot_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_req(slot_req),
    .slot_tmo(slot_tmo), .slot_ack(slot_ack), .host_irq(host_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model, advanced on each rising edge
  logic [7:0]  m_ctrl [4];
  logic [15:0] m_st;
  logic        m_lvl, m_pul;
  logic [7:0]  m_ack, m_reqq;

  always @(posedge clk or negedge rst_n) begin : model
    logic [15:0] nst;
    logic [15:0] msk;
    logic [6:0]  wi;
    bit          ev_l, ev_e;
    if (!rst_n) begin
      for (int n = 0; n < 4; n++) m_ctrl[n] = 8'h00;
      m_st = 0; m_lvl = 0; m_pul = 0; m_ack = 0; m_reqq = 0;
    end else begin
      wi = bus_addr[7:1];
      nst = m_st; msk = 0; ev_l = 0; ev_e = 0;
      for (int i = 0; i < 8; i++) begin
        if (m_ctrl[i/2][4 + i%2]) msk[i] = 1'b1;
        if (m_ctrl[i/2][6 + i%2] && slot_req[i] != m_reqq[i] && slot_req[i] != m_st[i]) begin
          nst[i] = slot_req[i];
          if (m_ctrl[i/2][4 + i%2]) begin
            if (slot_req[i]) ev_e = 1;
          end else ev_l = 1;
        end
      end
      for (int n = 0; n < 4; n++) begin
        if (bus_we && wi == 7'd6 && bus_wdata[12+n]) nst[12+n] = 1'b0;
        if (slot_tmo[n]) nst[12+n] = 1'b1;
      end
      m_ack = (bus_we && wi == 7'd6) ? bus_wdata[7:0] : 8'h00;
      m_pul = ev_e && !m_lvl;
      if (ev_l) m_lvl = |(nst & ~msk);
      m_st = nst;
      m_reqq = slot_req;
      if (bus_we && wi >= 7'd1 && wi <= 7'd4) m_ctrl[wi-1] = bus_wdata[7:0];
    end
  end

  function automatic logic [15:0] model_read(input logic [7:0] a);
    logic [6:0] wi;
    wi = a[7:1];
    if (wi >= 7'd1 && wi <= 7'd4) return {8'h00, m_ctrl[wi-1]};
    if (wi == 7'd6) return m_st;
    return 16'h0000;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk("R5 R6 host_irq", {15'd0, host_irq}, {15'd0, m_lvl | m_pul});
      chk("R8 slot_ack", {8'd0, slot_ack}, {8'd0, m_ack});
    end
  end

  task automatic rd_exp(input string tag, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_we = 0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    chk({tag, " model"}, bus_rdata, model_read(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic setreq(input int i, input logic v);
    @(negedge clk);
    slot_req[i] = v;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; slot_req = 0; slot_tmo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int n = 1; n <= 4; n++) rd_exp("R1 ctrl after reset", 8'(2*n), 16'h0000);
    rd_exp("R1 status after reset", 8'h0C, 16'h0000);
    chk("R1 host_irq after reset", {15'd0, host_irq}, 16'h0000);
    chk("R1 ack after reset", {8'd0, slot_ack}, 16'h0000);
    mon_on = 1;

    // R2 register map
    wr(8'h02, 16'hA5C3);
    rd_exp("R2 ctrl slot0 readback", 8'h02, 16'h00C3);
    rd_exp("R2 odd address aliases", 8'h03, 16'h00C3);
    wr(8'h00, 16'hFFFF);
    wr(8'h0A, 16'hFFFF);
    rd_exp("R2 revision reads zero", 8'h00, 16'h0000);
    rd_exp("R2 reset reg reads zero", 8'h0A, 16'h0000);
    rd_exp("R2 unmapped reads zero", 8'h0E, 16'h0000);
    rd_exp("R2 high unmapped reads zero", 8'h22, 16'h0000);
    rd_exp("R2 ctrl unchanged by ignored writes", 8'h02, 16'h00C3);

    // R3 switched-off line
    setreq(2, 1'b1);
    rd_exp("R3 off line leaves status", 8'h0C, 16'h0000);
    chk("R3 off line leaves host", {15'd0, host_irq}, 16'h0000);
    wr(8'h04, 16'h0040);
    rd_exp("R4 enable alone is not an event", 8'h0C, 16'h0000);
    setreq(2, 1'b0);
    rd_exp("R4 fall matching status no event", 8'h0C, 16'h0000);

    // R4 R5 level line
    setreq(2, 1'b1);
    rd_exp("R4 level line status set", 8'h0C, 16'h0004);
    chk("R5 level host asserted", {15'd0, host_irq}, 16'h0001);
    setreq(2, 1'b0);
    rd_exp("R4 level line status cleared", 8'h0C, 16'h0000);
    chk("R5 level host released", {15'd0, host_irq}, 16'h0000);

    // R6 edge line pulse
    wr(8'h06, 16'h0050);
    setreq(4, 1'b1);
    @(negedge clk); #1 chk("R6 edge pulse high", {15'd0, host_irq}, 16'h0001);
    bus_addr = 8'h0C; #1 chk("R4 edge status set", bus_rdata, 16'h0010);
    @(negedge clk); #1 chk("R6 edge pulse one clock", {15'd0, host_irq}, 16'h0000);
    setreq(4, 1'b0);
    @(negedge clk); #1 chk("R6 falling edge no host", {15'd0, host_irq}, 16'h0000);
    @(negedge clk); #1 chk("R6 falling edge no host later", {15'd0, host_irq}, 16'h0000);

    // R6 pulse suppressed while level held, R5 edge bits masked
    wr(8'h08, 16'h0050);
    setreq(2, 1'b1);
    @(negedge clk); #1 chk("R5 level held", {15'd0, host_irq}, 16'h0001);
    slot_req[6] = 1'b1;
    @(negedge clk); #1 chk("R6 no pulse over level", {15'd0, host_irq}, 16'h0001);
    @(negedge clk); #1 chk("R6 level still held", {15'd0, host_irq}, 16'h0001);
    slot_req[2] = 1'b0;
    @(negedge clk); #1 chk("R5 edge bit masked from level", {15'd0, host_irq}, 16'h0000);
    rd_exp("R5 edge bit still pending", 8'h0C, 16'h0040);

    // R8 acknowledge
    setreq(2, 1'b1);
    wr(8'h0C, 16'h0004);
    #1 chk("R8 ack pulse", {8'd0, slot_ack}, 16'h0004);
    rd_exp("R8 write does not clear bit", 8'h0C, 16'h0044);
    chk("R8 ack one clock", {8'd0, slot_ack}, 16'h0000);
    chk("R7 host steady without change", {15'd0, host_irq}, 16'h0001);
    setreq(2, 1'b0);
    setreq(6, 1'b0);
    rd_exp("R4 lines dropped", 8'h0C, 16'h0000);

    // R9 timeouts
    @(negedge clk); slot_tmo = 4'b0010;
    @(negedge clk); slot_tmo = 4'b0000;
    #1 bus_addr = 8'h0C; #1 chk("R9 timeout set", bus_rdata, 16'h2000);
    wr(8'h0C, 16'h2000);
    rd_exp("R9 timeout cleared", 8'h0C, 16'h0000);
    @(negedge clk); slot_tmo = 4'b1000; bus_we = 1; bus_addr = 8'h0C; bus_wdata = 16'h8000;
    @(negedge clk); slot_tmo = 4'b0000; bus_we = 0;
    #1 chk("R9 set beats clear", bus_rdata, 16'h8000);

    // R10 error bits
    wr(8'h0C, 16'h0F00);
    rd_exp("R10 error bits stay zero", 8'h0C, 16'h8000);
    wr(8'h0C, 16'h8000);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      bus_we = 0;
      slot_tmo = 0;
      for (int i = 0; i < 8; i++) begin
        if (slot_ack[i]) slot_req[i] = 1'b0;
        else if ($urandom % 16 == 0) slot_req[i] = ~slot_req[i];
      end
      if ($urandom % 40 == 0) slot_tmo = 4'(1 << ($urandom % 4));
      case ($urandom % 10)
        0: begin bus_we = 1; bus_addr = 8'(2 + 2 * ($urandom % 4)); bus_wdata = 16'($urandom); end
        1: begin bus_we = 1; bus_addr = 8'h0C; bus_wdata = 16'($urandom); end
        2, 3: begin
          bus_addr = 8'($urandom % 16);
          #1 chk("R2 R9 random read", bus_rdata, model_read(bus_addr));
        end
        default: ;
      endcase
    end
    @(negedge clk); bus_we = 0;
    rd_exp("R10 error bits zero after random", 8'h0C, model_read(8'h0C) & 16'hF0FF);
    finish_run();
  end
endmodule